// File: doc/BRIEF.md
# Escalating Virtual Channel Allocator

This block picks the downstream virtual channel that a header flit will occupy on one output port of a network router. Each of the five inputs presents a header request carrying the channel the packet currently travels on and its destination ID. Channels are handed out from the bottom upward. A packet takes the lowest free channel it is allowed and climbs to a higher-numbered one only when the lower one is taken. It never climbs back down. Under light load the upper channels therefore stay idle and can be kept power-gated.

A two-bit grouping mode splits the four channels into lanes selected by the destination. In single-lane mode all four channels form one ladder. In paired mode even destinations climb VC0 to VC1 and odd destinations climb VC2 to VC3. In pinned mode each packet is fixed to one channel and never escalates. Headers that can be served compete through a round-robin arbiter. At most one grant is issued per cycle, and it is combinational from the current inputs and state.

A two-state machine handles sleeping channels. In state READY the arbiter winner is granted at once if its channel is awake. If the channel is asleep, the machine raises a wake request for that channel and takes the transition READY to WAKING, holding the winner and its channel. In WAKING nothing else is granted. The wake request stays high while the channel reports asleep. In the first cycle the channel reports awake, the held header is granted and the machine takes the transition WAKING to READY. Reset places the machine in READY with arbiter priority at input 0.

Top module: `esc_vc_alloc`

## Requirements
- R1: While reset is held and just after it, with no header requesting, `gnt_valid` is 0, `gnt_port` is all zero and `wake_req` is all zero.
- R2: In single-lane mode (`grp_mode` = 0), the granted channel is the lowest-numbered channel that is at or above the header's current channel and is not busy.
- R3: A header on channel 0, which is the case for every packet entering the network, is granted VC0 whenever VC0 is free in single-lane mode.
- R4: In every mode except pinned, the granted channel is never lower than the requesting header's current channel.
- R5: In paired mode (`grp_mode` = 1), a header whose destination bit 0 is 0 may use only VC0 and VC1, and one with bit 0 equal to 1 may use only VC2 and VC3. Within its lane it takes the lowest free channel at or above both its current channel and the lane's base.
- R6: In pinned mode (`grp_mode` = 2), the only channel a header may get is destination mod 4, whatever its current channel. It is granted only while that channel is free.
- R7: A header with no free channel in its allowed range is not granted. It keeps waiting and is granted in the first cycle a channel in its range becomes free.
- R8: Round-robin arbitration: after input i is granted, priority starts at input i+1 (wrapping from 4 to 0), and inputs with no free channel are skipped.
- R9: At most one grant per cycle. `gnt_port` is one-hot on a grant and zero otherwise, it names a requesting input, and the granted channel is not busy.
- R10: If the winner's channel is asleep, no grant is issued and `wake_req` is one-hot on that channel. The grant to the held header comes in the first cycle the channel reports awake, with `wake_req` low in that cycle.
- R11: While a wake is pending, no other header is granted, even one whose channel is free and awake. Normal arbitration resumes after the held grant.
- R12: Mode value 3 behaves exactly as single-lane mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_mode | input | 2 | Lane grouping: 0 single lane, 1 paired, 2 pinned, 3 as 0 |
| req_valid | input | NUM_IN | Header request per input |
| req_vc | input | NUM_IN x VC_W | Current channel of each requesting header |
| req_dst | input | NUM_IN x DST_W | Destination ID of each requesting header |
| vc_busy | input | NUM_VC | Downstream channel occupied |
| vc_asleep | input | NUM_VC | Downstream channel power-gated |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_port | output | NUM_IN | One-hot granted input |
| gnt_vc | output | VC_W | Granted channel |
| wake_req | output | NUM_VC | Wake request for a sleeping chosen channel |

## Verification
The bench builds the block with five inputs, four channels and a three-bit destination. A single requester can then be swept over every mode, every current channel, all eight destinations and all sixteen busy patterns. Each of those points is compared with an arithmetic model of the lane and escalation rules. Short directed sequences then cover round-robin rotation with all five inputs requesting, skipping of inputs that cannot be served, blocking followed by release, and the full sleep-wake-grant sequence with a competing header present.

// File: rtl/esc_vca_pkg.sv
package esc_vca_pkg;

    typedef enum logic [1:0] {
        GRP_SINGLE = 2'd0,
        GRP_PAIRS  = 2'd1,
        GRP_PINNED = 2'd2,
        GRP_SPARE  = 2'd3
    } grp_mode_e;

    typedef enum logic {
        ST_READY  = 1'b0,
        ST_WAKING = 1'b1
    } alloc_state_e;

endpackage

// File: rtl/vca_vc_pick.sv
module vca_vc_pick
    import esc_vca_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int DST_W  = 6,
    localparam int VC_W  = $clog2(NUM_VC),
    localparam int HALF  = NUM_VC / 2
) (
    input  logic [1:0]        mode,
    input  logic [VC_W-1:0]   cur_vc,
    input  logic [DST_W-1:0]  dst,
    input  logic [NUM_VC-1:0] taken,
    output logic              ok,
    output logic [VC_W-1:0]   vc
);

    int lo;
    int hi;
    int base;

    always_comb begin
        base = 0;
        unique case (grp_mode_e'(mode))
            GRP_PAIRS: begin
                base = dst[0] ? HALF : 0;
                lo   = (int'(cur_vc) > base) ? int'(cur_vc) : base;
                hi   = base + HALF - 1;
            end
            GRP_PINNED: begin
                lo = int'(dst[VC_W-1:0]);
                hi = lo;
            end
            default: begin
                lo = int'(cur_vc);
                hi = NUM_VC - 1;
            end
        endcase
    end

    always_comb begin
        ok = 1'b0;
        vc = '0;
        for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (v >= lo && v <= hi && !taken[v]) begin
                ok = 1'b1;
                vc = VC_W'(v);
            end
        end
    end

endmodule

// File: rtl/vca_rr_arb.sv
module vca_rr_arb #(
    parameter int N      = 5,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     elig,
    input  logic             adv,
    input  logic [IDX_W-1:0] adv_idx,
    output logic             any,
    output logic [IDX_W-1:0] win
);

    logic [IDX_W-1:0] ptr;
    logic             found;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (int'(adv_idx) == N - 1) ? '0 : adv_idx + 1'b1;
        end
    end

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && elig[idx]) begin
                found = 1'b1;
                win   = IDX_W'(idx);
            end
        end
        any = found;
    end

endmodule

// File: rtl/esc_vc_alloc.sv
module esc_vc_alloc
    import esc_vca_pkg::*;
#(
    parameter int NUM_IN = 5,
    parameter int NUM_VC = 4,
    parameter int DST_W  = 6,
    localparam int VC_W  = $clog2(NUM_VC),
    localparam int IN_W  = $clog2(NUM_IN)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       grp_mode,
    input  logic [NUM_IN-1:0]                req_valid,
    input  logic [NUM_IN-1:0][VC_W-1:0]      req_vc,
    input  logic [NUM_IN-1:0][DST_W-1:0]     req_dst,
    input  logic [NUM_VC-1:0]                vc_busy,
    input  logic [NUM_VC-1:0]                vc_asleep,
    output logic                             gnt_valid,
    output logic [NUM_IN-1:0]                gnt_port,
    output logic [VC_W-1:0]                  gnt_vc,
    output logic [NUM_VC-1:0]                wake_req
);

    logic [NUM_IN-1:0]            pick_ok;
    logic [NUM_IN-1:0][VC_W-1:0]  pick_vc;
    logic [NUM_IN-1:0]            elig;
    logic                         arb_any;
    logic [IN_W-1:0]              arb_win;
    logic [VC_W-1:0]              win_vc;

    alloc_state_e                 state, state_nx;
    logic [IN_W-1:0]              held_port;
    logic [VC_W-1:0]              held_vc;
    logic                         capture;
    logic [IN_W-1:0]              gnt_idx;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_pick
        vca_vc_pick #(
            .NUM_VC (NUM_VC),
            .DST_W  (DST_W)
        ) u_pick (
            .mode   (grp_mode),
            .cur_vc (req_vc[i]),
            .dst    (req_dst[i]),
            .taken  (vc_busy),
            .ok     (pick_ok[i]),
            .vc     (pick_vc[i])
        );
    end

    assign elig   = req_valid & pick_ok;
    assign win_vc = pick_vc[arb_win];

    vca_rr_arb #(
        .N (NUM_IN)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .adv     (gnt_valid),
        .adv_idx (gnt_idx),
        .any     (arb_any),
        .win     (arb_win)
    );

    // State register and held selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READY;
            held_port <= '0;
            held_vc   <= '0;
        end else begin
            state <= state_nx;
            if (capture) begin
                held_port <= arb_win;
                held_vc   <= win_vc;
            end
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        unique case (state)
            ST_READY: begin
                if (arb_any && vc_asleep[win_vc]) begin
                    state_nx = ST_WAKING;
                    capture  = 1'b1;
                end
            end
            ST_WAKING: begin
                if (!vc_asleep[held_vc]) begin
                    state_nx = ST_READY;
                end
            end
            default: state_nx = ST_READY;
        endcase
    end

    // Outputs
    always_comb begin
        gnt_valid = 1'b0;
        gnt_port  = '0;
        gnt_vc    = '0;
        gnt_idx   = '0;
        wake_req  = '0;
        unique case (state)
            ST_READY: begin
                if (arb_any) begin
                    if (vc_asleep[win_vc]) begin
                        wake_req[win_vc] = 1'b1;
                    end else begin
                        gnt_valid         = 1'b1;
                        gnt_port[arb_win] = 1'b1;
                        gnt_vc            = win_vc;
                        gnt_idx           = arb_win;
                    end
                end
            end
            ST_WAKING: begin
                if (vc_asleep[held_vc]) begin
                    wake_req[held_vc] = 1'b1;
                end else begin
                    gnt_valid           = 1'b1;
                    gnt_port[held_port] = 1'b1;
                    gnt_vc              = held_vc;
                    gnt_idx             = held_port;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/esc_vc_alloc_chk.sv
module esc_vc_alloc_chk #(
    parameter int NUM_IN = 5,
    parameter int NUM_VC = 4,
    parameter int DST_W  = 6,
    localparam int VC_W  = $clog2(NUM_VC)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   grp_mode,
    input logic [NUM_IN-1:0]            req_valid,
    input logic [NUM_IN-1:0][VC_W-1:0]  req_vc,
    input logic [NUM_IN-1:0][DST_W-1:0] req_dst,
    input logic [NUM_VC-1:0]            vc_busy,
    input logic [NUM_VC-1:0]            vc_asleep,
    input logic                         gnt_valid,
    input logic [NUM_IN-1:0]            gnt_port,
    input logic [VC_W-1:0]              gnt_vc,
    input logic [NUM_VC-1:0]            wake_req
);

    int gidx;

    always_comb begin
        gidx = 0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (gnt_port[i]) gidx = i;
        end
    end

    p_one_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $countones(gnt_port) == 1);

    p_idle_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> gnt_port == '0);

    p_requested_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (gnt_port & req_valid) != '0);

    p_free_vc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> !vc_busy[gnt_vc]);

    p_no_downward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && grp_mode != 2'd2) |-> gnt_vc >= req_vc[gidx]);

    p_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && grp_mode == 2'd1) |-> gnt_vc[VC_W-1] == req_dst[gidx][0]);

    p_pinned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && grp_mode == 2'd2) |-> gnt_vc == req_dst[gidx][VC_W-1:0]);

    p_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> !vc_asleep[gnt_vc]);

    p_wake_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_req));

    p_wake_no_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req != '0) |-> !gnt_valid);

    p_wake_persist_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req != '0) |=> ((vc_asleep & $past(wake_req)) == '0) || (wake_req == $past(wake_req)));

endmodule

bind esc_vc_alloc esc_vc_alloc_chk #(
    .NUM_IN (NUM_IN),
    .NUM_VC (NUM_VC),
    .DST_W  (DST_W)
) u_chk (.*);

// File: tb/esc_vc_alloc_tb.sv
`timescale 1ns/1ps
module esc_vc_alloc_tb;

    localparam int NI = 5;
    localparam int NV = 4;
    localparam int DW = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        grp_mode;
    logic [NI-1:0]     req_valid;
    logic [NI-1:0][1:0]    req_vc;
    logic [NI-1:0][DW-1:0] req_dst;
    logic [NV-1:0]     vc_busy;
    logic [NV-1:0]     vc_asleep;
    logic              gnt_valid;
    logic [NI-1:0]     gnt_port;
    logic [1:0]        gnt_vc;
    logic [NV-1:0]     wake_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    esc_vc_alloc #(
        .NUM_IN (NI),
        .NUM_VC (NV),
        .DST_W  (DW)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_mode  (grp_mode),
        .req_valid (req_valid),
        .req_vc    (req_vc),
        .req_dst   (req_dst),
        .vc_busy   (vc_busy),
        .vc_asleep (vc_asleep),
        .gnt_valid (gnt_valid),
        .gnt_port  (gnt_port),
        .gnt_vc    (gnt_vc),
        .wake_req  (wake_req)
    );

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Expected channel from the lane and escalation rules
    task automatic model(input int mode, input int cur, input int dst, input int busy,
                         output bit ok, output int vc);
        int lo, hi;
        if (mode == 2) begin
            lo = dst % 4; hi = lo;
        end else if (mode == 1) begin
            lo = (dst % 2) * 2; hi = lo + 1;
            if (cur > lo) lo = cur;
        end else begin
            lo = cur; hi = 3;
        end
        ok = 1'b0; vc = 0;
        for (int v = lo; v <= hi; v++) begin
            if (!ok && ((busy >> v) & 1) == 0) begin
                ok = 1'b1; vc = v;
            end
        end
    endtask

    task automatic do_reset();
        req_valid = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R9 watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ok;
        int ev;
        string tag;
        rst_n = 1'b0; grp_mode = '0; req_valid = '0; req_vc = '0; req_dst = '0;
        vc_busy = '0; vc_asleep = '0;
        repeat (3) @(negedge clk);
        #1;
        check_eq("R1", "gnt_valid in reset", int'(gnt_valid), 0);
        check_eq("R1", "wake_req in reset", int'(wake_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_eq("R1", "gnt_valid after reset", int'(gnt_valid), 0);
        check_eq("R1", "gnt_port after reset", int'(gnt_port), 0);
        check_eq("R1", "wake_req after reset", int'(wake_req), 0);

        // Sweep: single requester on input 0
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 4; c++) begin
                for (int d = 0; d < 8; d++) begin
                    for (int b = 0; b < 16; b++) begin
                        @(negedge clk);
                        grp_mode   = 2'(m);
                        req_valid  = 5'b00001;
                        req_vc[0]  = 2'(c);
                        req_dst[0] = 3'(d);
                        vc_busy    = 4'(b);
                        #1;
                        model(m, c, d, b, ok, ev);
                        if (!ok)          tag = "R7";
                        else if (m == 2)  tag = "R6";
                        else if (m == 1)  tag = "R5";
                        else if (m == 3)  tag = "R12";
                        else if (c == 0)  tag = "R3";
                        else              tag = "R2";
                        check_eq(tag, "gnt_valid", int'(gnt_valid), int'(ok));
                        if (ok) begin
                            check_eq(tag, "gnt_vc", int'(gnt_vc), ev);
                            check_eq("R9", "gnt_port", int'(gnt_port), 1);
                        end else begin
                            check_eq("R9", "gnt_port idle", int'(gnt_port), 0);
                        end
                        if (gnt_valid && m != 2)
                            check_eq("R4", "no downward move", int'(int'(gnt_vc) >= c), 1);
                        check_eq("R10", "wake_req when awake", int'(wake_req), 0);
                    end
                end
            end
        end

        // R7: blocked header granted once a channel frees
        @(negedge clk);
        grp_mode = 2'd0; req_valid = 5'b00001; req_vc[0] = 2'd2; vc_busy = 4'b1100;
        #1;
        check_eq("R7", "blocked no grant", int'(gnt_valid), 0);
        @(negedge clk);
        vc_busy = 4'b1000;
        #1;
        check_eq("R7", "released grant", int'(gnt_valid), 1);
        check_eq("R7", "released vc", int'(gnt_vc), 2);

        // R8: rotation with all inputs requesting
        do_reset();
        grp_mode = 2'd0; vc_busy = '0; vc_asleep = '0; req_vc = '0; req_dst = '0;
        req_valid = 5'b11111;
        for (int k = 0; k < 7; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            check_eq("R8", "rotation port", int'(gnt_port), 1 << (k % 5));
            check_eq("R3", "rotation vc", int'(gnt_vc), 0);
            @(posedge clk);
        end

        // R8: ineligible input skipped (pinned mode)
        @(negedge clk);
        grp_mode = 2'd2; req_valid = 5'b01010;
        req_dst[1] = 3'd1; req_dst[3] = 3'd3; vc_busy = 4'b0010;
        for (int k = 0; k < 3; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            check_eq("R8", "skip port", int'(gnt_port), 5'b01000);
            check_eq("R6", "skip vc", int'(gnt_vc), 3);
        end
        @(negedge clk);
        vc_busy = '0;
        #1;
        check_eq("R8", "wrap port", int'(gnt_port), 5'b00010);
        check_eq("R6", "wrap vc", int'(gnt_vc), 1);
        @(negedge clk);
        #1;
        check_eq("R8", "next port", int'(gnt_port), 5'b01000);

        // R10/R11: wake sequence
        do_reset();
        grp_mode = 2'd0; vc_busy = '0; req_vc = '0; req_dst = '0;
        vc_asleep = 4'b0001; req_valid = 5'b00100;
        #1;
        check_eq("R10", "asleep no grant", int'(gnt_valid), 0);
        check_eq("R10", "wake onehot", int'(wake_req), 4'b0001);
        @(negedge clk);
        req_valid = 5'b00101; req_vc[0] = 2'd1;
        #1;
        check_eq("R11", "competitor held off", int'(gnt_valid), 0);
        check_eq("R10", "wake held", int'(wake_req), 4'b0001);
        @(negedge clk);
        vc_asleep = '0;
        #1;
        check_eq("R10", "held grant port", int'(gnt_port), 5'b00100);
        check_eq("R10", "held grant vc", int'(gnt_vc), 0);
        check_eq("R10", "wake low at grant", int'(wake_req), 0);
        @(negedge clk);
        req_valid = 5'b00001; vc_busy = 4'b0001;
        #1;
        check_eq("R11", "resume port", int'(gnt_port), 5'b00001);
        check_eq("R11", "resume vc", int'(gnt_vc), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule